// File: doc/BRIEF.md
# Host-to-Controller Mailbox Status Channel

This block is a single mailbox channel between a host I/O bus and a local controller processor, of the kind used to talk to a keyboard controller. The host writes a byte into an inbound data register and the controller reads it. The controller writes a byte into an outbound data register and the host reads it. A status byte carries the handshake flags for both directions, a command/data marker and a set of spare bits that the controller firmware owns.

The host side is a plain strobe interface: a 16-bit I/O address, a write strobe, a read strobe and 8-bit data. The channel answers only at its own base address. Address bit 2 chooses the status byte or the outbound byte on reads, and it supplies the command/data marker on writes. The controller side is a small register port with a two-bit selector and an interrupt output that is raised while the inbound register holds unread data.

Each direction is handled by a two-state handshake machine with states EMPTY and FULL. Inbound machine transitions: EMPTY to FULL on a host write (HOST_LOAD). FULL to EMPTY on a controller read (CTRL_DRAIN). FULL to FULL on a host write, which takes priority over a drain in the same cycle. Outbound machine transitions: EMPTY to FULL on a controller write (CTRL_LOAD). FULL to EMPTY on a host read (HOST_DRAIN). Both machines go to EMPTY on reset or on a standby request.

Top module: `mb_channel`

## Requirements
- R1: After `rst_n` low, or in the cycle after `standby` is high, the status byte reads 8'h00 and `irq` is 0.
- R2: A host write whose address bits 15:4 equal 12'h006, with bits 3, 1 and 0 at 0, loads the inbound register and sets status bit 1 (inbound full) from the next cycle.
- R3: On each such host write, address bit 2 is stored in status bit 3. 0 marks data and 1 marks a command. Both address forms load the inbound register.
- R4: A controller read with `c_sel`=2'd0 returns the inbound byte and clears status bit 1 from the next cycle.
- R5: `irq` equals status bit 1.
- R6: A controller write with `c_sel`=2'd2 changes only status bits 7:4 and 2. Bits 3, 1 and 0 keep their values.
- R7: A host read at the base address with bit 2 = 1 returns the status byte on `h_rdata` in the same cycle.
- R8: A controller write with `c_sel`=2'd1 loads the outbound byte and sets status bit 0. A host read at the base address with bit 2 = 0 returns that byte and clears bit 0 from the next cycle.
- R9: If a host write to the inbound register and a controller inbound read happen in the same cycle, status bit 1 stays 1.
- R10: Host accesses at any other address have no effect on state, and a read at such an address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of all channel state |
| h_addr | input | 16 | Host I/O address |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| c_sel | input | 2 | Controller selector: 0 inbound, 1 outbound, 2 status |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, combinational |
| irq | output | 1 | Interrupt to the controller: inbound full |

## Verification
Read data on both ports is combinational, so the bench samples `h_rdata` and `c_rdata` during the strobe cycle itself, one time unit after driving the inputs on the falling edge. Every flag change (inbound full, outbound full, command/data, spare bits, standby clear) lands on the rising edge that ends the strobe cycle. The bench therefore releases the strobe on the next falling edge and only then reads the status byte back. The same-cycle collision is driven on one falling edge, and its outcome is read one full cycle later.

// File: rtl/mb_pkg.sv
package mb_pkg;
    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

    typedef enum logic [1:0] {
        SEL_INBOUND  = 2'd0,
        SEL_OUTBOUND = 2'd1,
        SEL_STATUS   = 2'd2,
        SEL_NONE     = 2'd3
    } ctrl_sel_e;

    localparam int unsigned STS_CMD_BIT = 3;
    localparam int unsigned STS_IBF_BIT = 1;
    localparam int unsigned STS_OBF_BIT = 0;
    localparam logic [7:0]  STS_USER_MASK = 8'hF4;
endpackage

// File: rtl/mb_host_decode.sv
module mb_host_decode #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned HI_LSB  = 4,
    parameter logic [ADDR_W-HI_LSB-1:0] BASE_HI = 12'h006
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              hit_wr,
    output logic              hit_rd,
    output logic              sel_status
);
    logic match;

    always_comb begin
        match      = (addr[ADDR_W-1:HI_LSB] == BASE_HI) &&
                     !addr[3] && !addr[1] && !addr[0];
        hit_wr     = match && wr;
        hit_rd     = match && rd;
        sel_status = addr[2];
    end
endmodule

// File: rtl/mb_in_fsm.sv
module mb_in_fsm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              host_load,
    input  logic              cmd_in,
    input  logic [DATA_W-1:0] host_data,
    input  logic              ctrl_drain,
    output logic [DATA_W-1:0] idr,
    output logic              full,
    output logic              cmd
);
    import mb_pkg::*;

    buf_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (host_load) state_d = BUF_FULL;
            BUF_FULL:  if (ctrl_drain && !host_load) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
        if (clr) state_d = BUF_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            idr     <= '0;
            cmd     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                idr <= '0;
                cmd <= 1'b0;
            end else if (host_load) begin
                idr <= host_data;
                cmd <= cmd_in;
            end
        end
    end

    always_comb full = (state_q == BUF_FULL);

    a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_load && !clr) |=> full);
    a_r3_cmd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (host_load && !clr) |=> (cmd == $past(cmd_in)));
    a_r4_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_drain && !host_load) |=> !full);
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_drain && host_load && !clr) |=> full);
endmodule

// File: rtl/mb_out_fsm.sv
module mb_out_fsm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ctrl_load,
    input  logic [DATA_W-1:0] ctrl_data,
    input  logic              host_drain,
    output logic [DATA_W-1:0] odr,
    output logic              full
);
    import mb_pkg::*;

    buf_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (ctrl_load) state_d = BUF_FULL;
            BUF_FULL:  if (host_drain && !ctrl_load) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
        if (clr) state_d = BUF_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            odr     <= '0;
        end else begin
            state_q <= state_d;
            if (clr)            odr <= '0;
            else if (ctrl_load) odr <= ctrl_data;
        end
    end

    always_comb full = (state_q == BUF_FULL);

    a_r8_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_load && !clr) |=> full);
    a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_drain && !ctrl_load) |=> !full);
endmodule

// File: rtl/mb_channel.sv
module mb_channel #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-5:0] BASE_HI = 12'h006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [1:0]        c_sel,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic              irq
);
    import mb_pkg::*;

    logic              hit_wr, hit_rd, sel_status;
    logic [DATA_W-1:0] idr, odr, user_q, status;
    logic              ibf, obf, cmd;
    logic              ctrl_drain, ctrl_load, ctrl_sts_wr, host_drain;

    always_comb begin
        ctrl_drain  = c_rd && (ctrl_sel_e'(c_sel) == SEL_INBOUND);
        ctrl_load   = c_wr && (ctrl_sel_e'(c_sel) == SEL_OUTBOUND);
        ctrl_sts_wr = c_wr && (ctrl_sel_e'(c_sel) == SEL_STATUS);
        host_drain  = hit_rd && !sel_status;
    end

    mb_host_decode #(.ADDR_W(ADDR_W), .HI_LSB(4), .BASE_HI(BASE_HI)) u_dec (
        .addr(h_addr), .wr(h_wr), .rd(h_rd),
        .hit_wr(hit_wr), .hit_rd(hit_rd), .sel_status(sel_status)
    );

    mb_in_fsm #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .clr(standby),
        .host_load(hit_wr), .cmd_in(sel_status), .host_data(h_wdata),
        .ctrl_drain(ctrl_drain), .idr(idr), .full(ibf), .cmd(cmd)
    );

    mb_out_fsm #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(standby),
        .ctrl_load(ctrl_load), .ctrl_data(c_wdata),
        .host_drain(host_drain), .odr(odr), .full(obf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           user_q <= '0;
        else if (standby)     user_q <= '0;
        else if (ctrl_sts_wr) user_q <= c_wdata & STS_USER_MASK;
    end

    always_comb begin
        status = user_q;
        status[STS_CMD_BIT] = cmd;
        status[STS_IBF_BIT] = ibf;
        status[STS_OBF_BIT] = obf;
        irq = ibf;

        h_rdata = '0;
        if (h_rd && hit_rd) h_rdata = sel_status ? status : odr;

        unique case (ctrl_sel_e'(c_sel))
            SEL_INBOUND:  c_rdata = idr;
            SEL_OUTBOUND: c_rdata = odr;
            SEL_STATUS:   c_rdata = status;
            default:      c_rdata = '0;
        endcase
    end

    a_r1_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (status == 8'h00 && !irq));
    a_r6_sts_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sts_wr && !standby && !hit_wr && !ctrl_drain && !ctrl_load && !host_drain)
        |=> ($stable(status[3]) && $stable(status[1]) && $stable(status[0])));
    a_r10_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_wr || h_rd) && !hit_wr && !hit_rd && !c_wr && !c_rd && !standby)
        |=> $stable(status));
endmodule

// File: tb/test_mb_channel.sv
module test_mb_channel;
    localparam time CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, standby = 0;
    logic [15:0] h_addr = 0;
    logic        h_wr = 0, h_rd = 0;
    logic [7:0]  h_wdata = 0, h_rdata;
    logic [1:0]  c_sel = 2'd3;
    logic        c_wr = 0, c_rd = 0;
    logic [7:0]  c_wdata = 0, c_rdata;
    logic        irq;

    int checks = 0, errors = 0;
    localparam logic [15:0] A_DATA = 16'h0060;
    localparam logic [15:0] A_CMD  = 16'h0064;

    always #(CLK_PERIOD/2) clk = ~clk;

    mb_channel i_mb_channel (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0; c_sel = 2'd3; standby = 0;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
        @(negedge clk); idle();
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); h_addr = a; h_rd = 1; #1 d = h_rdata;
        @(negedge clk); idle();
    endtask

    task automatic ctrl_access(input logic [1:0] s, input logic w, input logic [7:0] d,
                               output logic [7:0] q);
        @(negedge clk); c_sel = s; c_wr = w; c_rd = !w; c_wdata = d; #1 q = c_rdata;
        @(negedge clk); idle();
    endtask

    function automatic logic [7:0] sts_peek();
        return 8'h00;
    endfunction

    task automatic read_status(output logic [7:0] s);
        host_read(A_CMD, s);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        read_status(s);
        chk("R1 reset status", s, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_host_write();
        logic [7:0] s, q;
        host_write(A_DATA, 8'hA5);
        read_status(s);
        chk("R2 ibf set, R3 data marker", s, 8'h02);
        chk("R5 irq follows ibf", {7'b0, irq}, 8'h01);
        ctrl_access(2'd0, 1'b0, 8'h00, q);
        chk("R4 inbound byte", q, 8'hA5);
        read_status(s);
        chk("R4 ibf cleared", s, 8'h00);
        chk("R5 irq low", {7'b0, irq}, 8'h00);
        host_write(A_CMD, 8'h3C);
        read_status(s);
        chk("R3 command marker", s, 8'h0A);
        ctrl_access(2'd0, 1'b0, 8'h00, q);
        chk("R3 command form loads inbound", q, 8'h3C);
    endtask

    task automatic t_user_bits();
        logic [7:0] s, q;
        ctrl_access(2'd2, 1'b1, 8'hFF, q);
        read_status(s);
        chk("R6 only spare bits written", s, 8'hFC);
        ctrl_access(2'd2, 1'b1, 8'h00, q);
        read_status(s);
        chk("R6 spare bits cleared, cmd kept", s, 8'h08);
    endtask

    task automatic t_outbound();
        logic [7:0] s, d;
        ctrl_access(2'd1, 1'b1, 8'h5A, d);
        read_status(s);
        chk("R8 obf set", s, 8'h09);
        chk("R7 status via host", s[0] ? 8'h01 : 8'h00, 8'h01);
        host_read(A_DATA, d);
        chk("R8 outbound byte", d, 8'h5A);
        read_status(s);
        chk("R8 obf cleared", s, 8'h08);
    endtask

    task automatic t_collision();
        logic [7:0] s, q;
        host_write(A_DATA, 8'h11);
        @(negedge clk);
        h_addr = A_DATA; h_wdata = 8'h22; h_wr = 1; c_sel = 2'd0; c_rd = 1;
        @(negedge clk); idle();
        read_status(s);
        chk("R9 set wins over drain", s, 8'h02);
        ctrl_access(2'd0, 1'b0, 8'h00, q);
        chk("R9 latest byte held", q, 8'h22);
    endtask

    task automatic t_miss();
        logic [7:0] s, d;
        host_write(16'h0070, 8'h77);
        host_write(16'h0061, 8'h77);
        read_status(s);
        chk("R10 miss write ignored", s, 8'h00);
        ctrl_access(2'd1, 1'b1, 8'h44, d);
        host_read(16'h0068, d);
        chk("R10 miss read returns zero", d, 8'h00);
        read_status(s);
        chk("R10 miss read keeps obf", s, 8'h01);
    endtask

    task automatic t_standby();
        logic [7:0] s, q;
        ctrl_access(2'd2, 1'b1, 8'hF4, q);
        host_write(A_CMD, 8'h99);
        @(negedge clk); standby = 1;
        @(negedge clk); idle();
        read_status(s);
        chk("R1 standby clears status", s, 8'h00);
        chk("R1 standby clears irq", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_host_write();
        t_user_bits();
        t_outbound();
        t_collision();
        t_miss();
        t_standby();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule